// File: doc/BRIEF.md
# Register-Bus Bridge with Local Intercepts

This block sits between a host port and a downstream register bus. The host port carries 64-bit memory-mapped reads and writes. The bridge turns each host byte address into a 32-bit register index, using a translation that a parameter selects per chip variant. The downstream byte address is that index times eight, so every register owns one 8-byte slot. Before it starts a downstream transaction, the bridge compares the index against a small built-in table. A matching access is completed on the spot and never reaches the bus. The set of indices answered locally differs between reads and writes.

Every completed access posts sticky status bits, DONE and FAIL, into a two-bit register that the host polls. The bridge only ever sets these bits. The host clears them through a write-one-to-clear mask input. Accesses issued from the debug port carry no core context and leave the status untouched.

A downstream access fails when the bus acknowledges with an error, or when no acknowledge arrives within a configurable number of cycles. Only whole 8-byte accesses are accepted. Any other size is rejected with an error response and no bus activity.

Top module: `regbus_bridge`

## Requirements
- R1: An access whose `h_size` is not 8 gets a one-cycle response with `h_rerr`=1 and `h_rdata`=0. It raises no `d_req` and leaves `stat` unchanged.
- R2: A forwarded access drives `d_addr` = {index, 3'b000}. With `XLATE_MODE`=1 (gapped), the index is {haddr[35:8], haddr[6:3]}. With mode 0 (linear), the index is haddr[34:3]. `d_write` and `d_wdata` reflect the host access.
- R3: A read of index 0x000F000F returns `CHIP_ID` without any downstream request. A write to that index is discarded locally.
- R4: Reads of the zero-read list complete locally with data 0 and no downstream request. The list includes 0x00018002, 0x01010C00, 0x01010C03, 0x00090012, 0x00090013, 0x00090018 and 0x02013F01.
- R5: Writes to the write-discard list complete locally with no downstream request. The list includes 0x00090013, 0x01010C01, 0x01010C02, 0x01010C04 and 0x01010C05. Reads of 0x01010C01, 0x01010C02, 0x01010C04 and 0x01010C05 are forwarded. Writes to 0x00018002 and 0x02013F01 are forwarded.
- R6: A downstream acknowledge with `d_err`=1 returns read data 0 and ORs both FAIL (`stat[1]`) and DONE (`stat[0]`) into the status.
- R7: `d_req` is held until `d_ack`. If `d_ack` has not arrived by the `TIMEOUT`-th request cycle, the access fails as in R6. An acknowledge in that last cycle still counts as success.
- R8: A successful access, whether local or forwarded, ORs in DONE only. The bridge never clears a status bit.
- R9: An access with `h_core_ctx`=0 completes normally but leaves `stat` unchanged.
- R10: Each 1 in `stat_clr` clears the matching status bit on the next edge. A bit being set in the same cycle wins over its clear.
- R11: `h_ready` is high only while idle, so at most one access is in flight. Each accepted access produces exactly one single-cycle `h_rvalid` pulse, after which `h_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | HADDR_W | Host byte address |
| h_size | input | 4 | Access size in bytes (must be 8) |
| h_wdata | input | 64 | Host write data |
| h_core_ctx | input | 1 | 1 = issued by a core, 0 = debug port |
| h_rvalid | output | 1 | Single-cycle response strobe |
| h_rdata | output | 64 | Read data (0 outside a response) |
| h_rerr | output | 1 | Response flags a rejected size |
| stat | output | 2 | Sticky status: bit1 FAIL, bit0 DONE |
| stat_clr | input | 2 | Write-one-to-clear mask for `stat` |
| d_req | output | 1 | Downstream request, held until ack or timeout |
| d_write | output | 1 | Downstream direction |
| d_addr | output | IDX_W+3 | Downstream byte address |
| d_wdata | output | 64 | Downstream write data |
| d_ack | input | 1 | Downstream acknowledge |
| d_err | input | 1 | Downstream error, valid with `d_ack` |
| d_rdata | input | 64 | Downstream read data, valid with `d_ack` |

## Verification
The bench builds the bridge with `XLATE_MODE`=1, so every host address goes through the gapped translation, and any slip in the discarded bit 7 or the split index shows up in `d_addr`. `TIMEOUT` is set to 8. This keeps both sides of the timeout boundary within a few cycles: an acknowledge in the eighth request cycle still succeeds, and one in the ninth is too late. `CHIP_ID` is a distinctive 64-bit pattern, so a chip-identification read cannot be confused with a zero-read intercept or with forwarded data.

// File: rtl/regbus_bridge_pkg.sv
package regbus_bridge_pkg;

    localparam int IDX_W = 32;

    localparam logic [IDX_W-1:0] CHIP_ID_IDX = 32'h000F_000F;

    // indices intercepted for both reads (return zero) and writes (discarded)
    localparam int N_SHARED = 24;
    localparam logic [IDX_W-1:0] SHARED_LIST [N_SHARED] = '{
        32'h0009_0012, 32'h0009_0013, 32'h0009_0018, 32'h000F_0033,
        32'h000F_0034, 32'h0101_0C00, 32'h0101_0C03, 32'h0102_0013,
        32'h0102_0014, 32'h0201_0828, 32'h0201_082A, 32'h0201_0841,
        32'h0201_0842, 32'h0201_3028, 32'h0201_302A, 32'h0201_3801,
        32'h0201_3802, 32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
        32'h0401_0828, 32'h0401_082A, 32'h0401_0841, 32'h0401_0842
    };

    // indices that read as zero but whose writes are forwarded
    localparam int N_RD_ONLY = 3;
    localparam logic [IDX_W-1:0] RD_ONLY_LIST [N_RD_ONLY] = '{
        32'h0001_8002, 32'h0201_3F01, 32'h0201_3F05
    };

    // indices whose writes are discarded but whose reads are forwarded
    localparam int N_WR_ONLY = 4;
    localparam logic [IDX_W-1:0] WR_ONLY_LIST [N_WR_ONLY] = '{
        32'h0101_0C01, 32'h0101_0C02, 32'h0101_0C04, 32'h0101_0C05
    };

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DOWN = 2'd1,
        ST_RESP = 2'd2
    } br_state_e;

    localparam int STAT_DONE = 0;
    localparam int STAT_FAIL = 1;

endpackage

// File: rtl/regbus_addr_xlate.sv
module regbus_addr_xlate #(
    parameter int HADDR_W    = 40,
    parameter int IDX_W      = 32,
    parameter int XLATE_MODE = 0
) (
    input  logic [HADDR_W-1:0] haddr,
    output logic [IDX_W-1:0]   idx
);
    logic unused_haddr;
    assign unused_haddr = ^haddr;

    generate
        if (XLATE_MODE == 1) begin : g_gapped
            // bit 7 skipped: low nibble from [6:3], rest from [IDX_W+3:8]
            assign idx = {haddr[IDX_W+3:8], haddr[6:3]};
        end else begin : g_linear
            assign idx = haddr[IDX_W+2:3];
        end
    endgenerate

    initial begin
        assert (HADDR_W >= IDX_W + 4)
            else $error("host address too narrow for translation");
    end
endmodule

// File: rtl/regbus_intercept.sv
module regbus_intercept
    import regbus_bridge_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic             rd_hit,
    output logic             wr_hit,
    output logic             rd_is_id
);
    logic [N_SHARED-1:0]  shared_m;
    logic [N_RD_ONLY-1:0] rdonly_m;
    logic [N_WR_ONLY-1:0] wronly_m;

    generate
        for (genvar i = 0; i < N_SHARED; i++) begin : g_shared
            assign shared_m[i] = (idx == SHARED_LIST[i]);
        end
        for (genvar i = 0; i < N_RD_ONLY; i++) begin : g_rdonly
            assign rdonly_m[i] = (idx == RD_ONLY_LIST[i]);
        end
        for (genvar i = 0; i < N_WR_ONLY; i++) begin : g_wronly
            assign wronly_m[i] = (idx == WR_ONLY_LIST[i]);
        end
    endgenerate

    assign rd_is_id = (idx == CHIP_ID_IDX);
    assign rd_hit   = rd_is_id | (|shared_m) | (|rdonly_m);
    assign wr_hit   = rd_is_id | (|shared_m) | (|wronly_m);
endmodule

// File: rtl/regbus_status.sv
module regbus_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_fail,
    input  logic [1:0] stat_clr,
    output logic [1:0] stat_q
);
    logic [1:0] stat_d;

    always_comb begin
        stat_d = (stat_q & ~stat_clr) | {set_fail, set_done};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 2'b00;
        else        stat_q <= stat_d;
    end

    // R8: without a clear request no bit ever drops
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr == 2'b00) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6: a failure is always reported together with completion
    assert_fail_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_fail |-> set_done);

    // R10: a set in the same cycle as its clear survives
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_done && stat_clr[0]) |=> stat_q[0]);
endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
    import regbus_bridge_pkg::*;
#(
    parameter int          HADDR_W    = 40,
    parameter int          XLATE_MODE = 0,
    parameter int          TIMEOUT    = 1024,
    parameter logic [63:0] CHIP_ID    = 64'h0000_0000_220D_1049
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_valid,
    output logic                 h_ready,
    input  logic                 h_write,
    input  logic [HADDR_W-1:0]   h_addr,
    input  logic [3:0]           h_size,
    input  logic [63:0]          h_wdata,
    input  logic                 h_core_ctx,
    output logic                 h_rvalid,
    output logic [63:0]          h_rdata,
    output logic                 h_rerr,
    output logic [1:0]           stat,
    input  logic [1:0]           stat_clr,
    output logic                 d_req,
    output logic                 d_write,
    output logic [IDX_W+2:0]     d_addr,
    output logic [63:0]          d_wdata,
    input  logic                 d_ack,
    input  logic                 d_err,
    input  logic [63:0]          d_rdata
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        br_state_e        st;
        logic [IDX_W-1:0] idx;
        logic             wr;
        logic [63:0]      wdata;
        logic             ctx;
        logic [63:0]      rdata;
        logic             err;
        logic [CNT_W-1:0] cnt;
    } br_regs_t;

    br_regs_t q, d;

    logic [IDX_W-1:0] idx_w;
    logic             rd_hit, wr_hit, rd_is_id;
    logic             set_done, set_fail;

    regbus_addr_xlate #(
        .HADDR_W   (HADDR_W),
        .IDX_W     (IDX_W),
        .XLATE_MODE(XLATE_MODE)
    ) u_xlate (
        .haddr(h_addr),
        .idx  (idx_w)
    );

    regbus_intercept u_icpt (
        .idx     (idx_w),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit),
        .rd_is_id(rd_is_id)
    );

    regbus_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_done(set_done),
        .set_fail(set_fail),
        .stat_clr(stat_clr),
        .stat_q  (stat)
    );

    always_comb begin
        d        = q;
        set_done = 1'b0;
        set_fail = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (h_valid) begin
                    d.wr    = h_write;
                    d.idx   = idx_w;
                    d.wdata = h_wdata;
                    d.ctx   = h_core_ctx;
                    d.cnt   = '0;
                    d.err   = 1'b0;
                    d.rdata = '0;
                    if (h_size != 4'd8) begin
                        d.err = 1'b1;
                        d.st  = ST_RESP;
                    end else if (h_write ? wr_hit : rd_hit) begin
                        d.rdata  = (!h_write && rd_is_id) ? CHIP_ID : 64'd0;
                        d.st     = ST_RESP;
                        set_done = h_core_ctx;
                    end else begin
                        d.st = ST_DOWN;
                    end
                end
            end
            ST_DOWN: begin
                if (d_ack) begin
                    d.st     = ST_RESP;
                    d.rdata  = (!q.wr && !d_err) ? d_rdata : 64'd0;
                    set_done = q.ctx;
                    set_fail = q.ctx && d_err;
                end else if (q.cnt == CNT_LAST) begin
                    d.st     = ST_RESP;
                    d.rdata  = '0;
                    set_done = q.ctx;
                    set_fail = q.ctx;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign h_ready  = (q.st == ST_IDLE);
    assign h_rvalid = (q.st == ST_RESP);
    assign h_rdata  = (q.st == ST_RESP) ? q.rdata : 64'd0;
    assign h_rerr   = (q.st == ST_RESP) && q.err;
    assign d_req    = (q.st == ST_DOWN);
    assign d_write  = q.wr;
    assign d_addr   = {q.idx, 3'b000};
    assign d_wdata  = q.wdata;

    // R1: a wrong size goes straight to an error response
    assert_badsize_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && h_ready && h_size != 4'd8) |=> (!d_req && h_rvalid && h_rerr));

    // R3 / R4 / R5: intercepted indices never reach the bus
    assert_local_nodown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && h_ready && h_size == 4'd8 && (h_write ? wr_hit : rd_hit))
        |=> (!d_req && h_rvalid));

    // R7: request held while no ack and the window is open
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && !d_ack && q.cnt != CNT_LAST) |=> d_req);

    // R7: wait counter stays inside its window
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        d_req |-> (q.cnt <= CNT_LAST));

    // R11: one response per access, then ready again
    assert_one_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |=> (!h_rvalid && h_ready));

    // R11: busy after accepting
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && h_ready) |=> !h_ready);
endmodule

// File: tb/regbus_bridge_tb.sv
module regbus_bridge_tb;
    localparam int          HADDR_W = 40;
    localparam int          TMO     = 8;
    localparam logic [63:0] CID     = 64'h5EC7_0A11_9B3D_C0DE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              h_valid = 1'b0, h_write = 1'b0, h_core_ctx = 1'b1;
    logic [HADDR_W-1:0] h_addr = '0;
    logic [3:0]        h_size = 4'd8;
    logic [63:0]       h_wdata = '0;
    logic [1:0]        stat_clr = 2'b00;
    logic              h_ready, h_rvalid, h_rerr, d_req, d_write;
    logic [63:0]       h_rdata, d_wdata;
    logic [1:0]        stat;
    logic [34:0]       d_addr;
    logic              d_ack = 1'b0, d_err = 1'b0;
    logic [63:0]       d_rdata = '0;

    always #2.5 clk = ~clk;

    regbus_bridge #(
        .HADDR_W(HADDR_W), .XLATE_MODE(1), .TIMEOUT(TMO), .CHIP_ID(CID)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
        .h_write(h_write), .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata),
        .h_core_ctx(h_core_ctx), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .h_rerr(h_rerr), .stat(stat), .stat_clr(stat_clr), .d_req(d_req),
        .d_write(d_write), .d_addr(d_addr), .d_wdata(d_wdata), .d_ack(d_ack),
        .d_err(d_err), .d_rdata(d_rdata)
    );

    int n_tests = 0, n_fail = 0;

    // downstream responder
    int          rsp_dly = 0;
    logic        rsp_err = 1'b0;
    logic [63:0] rsp_rd = '0;
    int          rsp_cnt = 0;
    logic        rsp_done = 1'b0, seen_req = 1'b0, seen_wr = 1'b0;
    logic [34:0] seen_addr = '0;
    logic [63:0] seen_wdata = '0;

    always @(negedge clk) begin
        d_ack = 1'b0;
        if (d_req && !rsp_done) begin
            seen_req   = 1'b1;
            seen_addr  = d_addr;
            seen_wr    = d_write;
            seen_wdata = d_wdata;
            if (rsp_cnt == rsp_dly) begin
                d_ack    = 1'b1;
                d_err    = rsp_err;
                d_rdata  = rsp_rd;
                rsp_done = 1'b1;
            end else begin
                rsp_cnt++;
            end
        end
    end

    function automatic logic [HADDR_W-1:0] addr_of(input logic [31:0] idx);
        addr_of = (HADDR_W'(idx[31:4]) << 8) | (HADDR_W'(idx[3:0]) << 3);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [63:0] got_rd;
    logic        got_err, got_rdy_busy, got_rdy_after, got_rv_after;

    task automatic run_txn(input logic wr, input logic [31:0] idx,
                           input logic [3:0] sz, input logic [63:0] wd,
                           input logic ctx, input int dly, input logic derr,
                           input logic [63:0] drd, input logic [1:0] clr);
        @(negedge clk);
        rsp_dly = dly; rsp_err = derr; rsp_rd = drd;
        rsp_cnt = 0; rsp_done = 1'b0; seen_req = 1'b0; seen_addr = '0;
        h_valid = 1'b1; h_write = wr; h_addr = addr_of(idx); h_size = sz;
        h_wdata = wd; h_core_ctx = ctx; stat_clr = clr;
        @(negedge clk);
        h_valid = 1'b0; stat_clr = 2'b00;
        got_rdy_busy = h_ready;
        for (int i = 0; i < 40 && !h_rvalid; i++) @(negedge clk);
        got_rd  = h_rdata;
        got_err = h_rerr;
        @(negedge clk);
        got_rv_after  = h_rvalid;
        got_rdy_after = h_ready;
    endtask

    task automatic clear_stat;
        @(negedge clk); stat_clr = 2'b11;
        @(negedge clk); stat_clr = 2'b00;
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] idx;
        logic [63:0] wdata;
        logic [7:0]  dly;
        logic        derr;
        logic [63:0] drd;
        logic        exp_fwd;
        logic [63:0] exp_rd;
        logic [1:0]  exp_st;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R3 chip id read
        '{1'b0, 32'h000F_000F, 64'h0, 8'd0, 1'b0, 64'h0, 1'b0, CID, 2'b01, 4'd3},
        // R4 zero reads
        '{1'b0, 32'h0001_8002, 64'h0, 8'd0, 1'b0, 64'h0, 1'b0, 64'h0, 2'b01, 4'd4},
        '{1'b0, 32'h0101_0C03, 64'h0, 8'd0, 1'b0, 64'h0, 1'b0, 64'h0, 2'b01, 4'd4},
        '{1'b0, 32'h0201_3F01, 64'h0, 8'd0, 1'b0, 64'h0, 1'b0, 64'h0, 2'b01, 4'd4},
        // R5 discarded writes
        '{1'b1, 32'h0009_0013, 64'h11, 8'd0, 1'b0, 64'h0, 1'b0, 64'h0, 2'b01, 4'd5},
        '{1'b1, 32'h0101_0C04, 64'h22, 8'd0, 1'b0, 64'h0, 1'b0, 64'h0, 2'b01, 4'd5},
        // R5 / R2 forwarded asymmetric entries
        '{1'b0, 32'h0101_0C04, 64'h0, 8'd2, 1'b0, 64'hA5A5_0101_5A5A_F00D, 1'b1, 64'hA5A5_0101_5A5A_F00D, 2'b01, 4'd5},
        '{1'b1, 32'h0001_8002, 64'hDEAD_BEEF_0000_0001, 8'd0, 1'b0, 64'h0, 1'b1, 64'h0, 2'b01, 4'd5},
        '{1'b1, 32'h0201_3F01, 64'h0123_4567_89AB_CDEF, 8'd1, 1'b0, 64'h0, 1'b1, 64'h0, 2'b01, 4'd2},
        // R7 ack in last cycle succeeds, one later times out
        '{1'b0, 32'h0012_3456, 64'h0, 8'd7, 1'b0, 64'hCAFE_0000_0000_0007, 1'b1, 64'hCAFE_0000_0000_0007, 2'b01, 4'd7},
        '{1'b0, 32'h0012_3457, 64'h0, 8'd8, 1'b0, 64'hCAFE_0000_0000_0008, 1'b1, 64'h0, 2'b11, 4'd7},
        // R6 downstream error
        '{1'b0, 32'h0020_0000, 64'h0, 8'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, 2'b11, 4'd6},
        '{1'b1, 32'h0020_0008, 64'h77, 8'd0, 1'b1, 64'h0, 1'b1, 64'h0, 2'b11, 4'd6}
    };

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R8, R11)
        check("R11", "ready after reset", 64'(h_ready), 64'd1);
        check("R8", "status after reset", 64'(stat), 64'd0);
        check("R7", "no request after reset", 64'(d_req), 64'd0);

        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d vec%0d", VECS[v].req, v);
            clear_stat();
            run_txn(VECS[v].wr, VECS[v].idx, 4'd8, VECS[v].wdata, 1'b1,
                    int'(VECS[v].dly), VECS[v].derr, VECS[v].drd, 2'b00);
            check(rq, "forwarded", 64'(seen_req), 64'(VECS[v].exp_fwd));
            if (!VECS[v].wr) check(rq, "rdata", got_rd, VECS[v].exp_rd);
            check(rq, "status", 64'(stat), 64'(VECS[v].exp_st));
            if (VECS[v].exp_fwd) begin
                check("R2", "d_addr", 64'(seen_addr), 64'({VECS[v].idx, 3'b000}));
                check("R2", "d_write", 64'(seen_wr), 64'(VECS[v].wr));
                if (VECS[v].wr) check("R2", "d_wdata", seen_wdata, VECS[v].wdata);
            end
        end

        // R1: bad size rejected, no bus, status untouched
        clear_stat();
        run_txn(1'b0, 32'h0030_0000, 4'd4, 64'h0, 1'b1, 0, 1'b0, 64'h99, 2'b00);
        check("R1", "err flag", 64'(got_err), 64'd1);
        check("R1", "rdata", got_rd, 64'd0);
        check("R1", "no request", 64'(seen_req), 64'd0);
        check("R1", "status", 64'(stat), 64'd0);

        // R3: chip id write discarded, read still returns ID
        run_txn(1'b1, 32'h000F_000F, 4'd8, 64'h1, 1'b1, 0, 1'b0, 64'h0, 2'b00);
        check("R3", "id write no request", 64'(seen_req), 64'd0);
        run_txn(1'b0, 32'h000F_000F, 4'd8, 64'h0, 1'b1, 0, 1'b0, 64'h0, 2'b00);
        check("R3", "id read after write", got_rd, CID);

        // R9: debug-port accesses leave status alone
        clear_stat();
        run_txn(1'b0, 32'h0009_0018, 4'd8, 64'h0, 1'b0, 0, 1'b0, 64'h0, 2'b00);
        check("R9", "local status", 64'(stat), 64'd0);
        run_txn(1'b0, 32'h0040_0000, 4'd8, 64'h0, 1'b0, 1, 1'b1, 64'h5, 2'b00);
        check("R9", "error status", 64'(stat), 64'd0);
        check("R9", "error rdata", got_rd, 64'd0);

        // R8: sticky accumulation
        run_txn(1'b0, 32'h0009_0018, 4'd8, 64'h0, 1'b1, 0, 1'b0, 64'h0, 2'b00);
        check("R8", "done set", 64'(stat), 64'd1);
        run_txn(1'b0, 32'h0040_0000, 4'd8, 64'h0, 1'b1, 0, 1'b1, 64'h0, 2'b00);
        check("R8", "fail added", 64'(stat), 64'd3);
        run_txn(1'b0, 32'h0040_0001, 4'd8, 64'h0, 1'b1, 0, 1'b0, 64'h6, 2'b00);
        check("R8", "success keeps fail", 64'(stat), 64'd3);

        // R10: clear in the same cycle as a DONE set
        run_txn(1'b0, 32'h0009_0012, 4'd8, 64'h0, 1'b1, 0, 1'b0, 64'h0, 2'b11);
        check("R10", "set wins, fail cleared", 64'(stat), 64'd1);
        clear_stat();
        check("R10", "cleared", 64'(stat), 64'd0);

        // R11: busy during a forwarded access, single response pulse
        run_txn(1'b0, 32'h0050_0000, 4'd8, 64'h0, 1'b1, 4, 1'b0, 64'h42, 2'b00);
        check("R11", "busy after accept", 64'(got_rdy_busy), 64'd0);
        check("R11", "pulse ends", 64'(got_rv_after), 64'd0);
        check("R11", "ready again", 64'(got_rdy_after), 64'd1);
        check("R11", "rdata", got_rd, 64'h42);

        finish_run();
    end
endmodule